// File: doc/BRIEF.md
# Oversampled UART Receive Engine

This block turns an asynchronous serial stream on one input line into parallel words. A free-running strobe at sixteen times the baud rate paces it. The line first passes through a two-flop synchronizer. While the receiver is idle, a falling edge on the synchronized line starts a frame. Every bit, including the start and stop bits, is then decided by a 2-of-3 majority vote. The three samples are taken on the 7th, 8th and 9th strobes of that bit's 16-strobe period.

After the start bit, eight data bits arrive least significant first, or nine when the width-select input is high. That input is captured when the frame starts. The stop bit is then voted. The finished word is presented for one clock together with a framing-error flag. Word and flag stay unchanged until the next word. The enable input also serves as a soft reset: while it is low, the engine stays idle and discards any partial frame.

The controller has four states:
- `RX_IDLE` waits for a falling edge.
- `RX_START` validates the start bit.
- `RX_DATA` shifts in data bits.
- `RX_STOP` checks the stop bit.

Its transitions are:
- *edge*: `RX_IDLE` to `RX_START`.
- *false start*: `RX_START` to `RX_IDLE`, when the start vote is high.
- *start ok*: `RX_START` to `RX_DATA`.
- *last bit*: `RX_DATA` to `RX_STOP`.
- *frame done*: `RX_STOP` to `RX_IDLE`.
- *disable*: from any state to `RX_IDLE`, when `rx_en` is low.

Top module: `uart_os_rx`

## Requirements
- R1: After `rst_n` is released, `word_valid`, `word_data` and `frame_err` are all zero.
- R2: A frame starts only on a strobe where the synchronized line is low and the previous strobe saw it high. A line held low since enable therefore starts nothing.
- R3: If the majority vote of the start bit is high, the engine returns to `RX_IDLE` and produces no word.
- R4: Each bit value is the majority of the samples on strobes 7, 8 and 9 of its 16-strobe period. One disagreeing sample does not change the bit. Two disagreeing samples do.
- R5: With `nine_bit_mode` low, the first data bit lands in `word_data[0]`, data bits fill `word_data[7:0]` LSB first, and `word_data[8]` is 0.
- R6: With `nine_bit_mode` high when the frame starts, a ninth data bit is received into `word_data[8]`.
- R7: `frame_err` is 1 with a word whose voted stop bit is low, and 0 when it is high. The word is delivered in both cases.
- R8: `word_valid` is high for exactly one clock per completed frame. `word_data` and `frame_err` hold their values between strobes.
- R9: While `rx_en` is low, the engine is idle one clock later and produces no word. A frame interrupted by disable is discarded.
- R10: The engine is ready for the next falling edge right after the stop-bit vote, so back-to-back frames with a single stop bit are received.
- R11: The engine changes state only on clocks where `tick_x16` is high. Line activity between strobes has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_x16 | input | 1 | One-clock strobe at 16 times the baud rate |
| rx_en | input | 1 | Receive enable; low holds the engine idle |
| nine_bit_mode | input | 1 | High selects nine data bits, captured at frame start |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| word_valid | output | 1 | One-clock strobe for a finished word |
| word_data | output | 9 | Received word; bit 8 is 0 in eight-bit mode |
| frame_err | output | 1 | Stop bit voted low for this word |

## Verification
The hardest situation to reach from the ports is a line that disagrees with itself inside one bit. The vote must see one or two opposing samples exactly on strobes 7 to 9, counted from the strobe that detected the start edge. The bench drives the line one value per strobe, with the change placed three clocks before each strobe, so it knows which strobe number of the engine sees each value. It flips the line on in-bit strobe 8 alone, or on strobes 7 and 8 together, for a chosen bit of the frame. The same per-strobe control produces a start bit that is low for only four strobes, a disable in the middle of a frame, and a gap in the strobes while the line toggles.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    // Two-of-three vote used for every bit decision.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RESET_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_os_rx_phase.sv
// Tracks the strobe position inside a bit period and votes the line
// on the three strobes around the middle of the period.
module uart_os_rx_phase
    import uart_os_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,   // strobe that found the start edge counts as strobe 1
    input  logic run,
    input  logic line,
    output logic bit_done,  // strobe at which the third sample is taken
    output logic bit_val
);

    localparam int CW  = $clog2(OVERSAMPLE);
    localparam int MID = OVERSAMPLE / 2;
    // Counter holds strobes already elapsed; strobe number is cnt + 1.
    localparam logic [CW-1:0] AT_FIRST  = CW'(MID - 2);
    localparam logic [CW-1:0] AT_SECOND = CW'(MID - 1);
    localparam logic [CW-1:0] AT_THIRD  = CW'(MID);

    logic [CW-1:0] cnt;
    logic          samp_a;
    logic          samp_b;
    logic          step;

    assign step = run && tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CW'(1);
        end else if (step) begin
            cnt <= cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else if (step) begin
            if (cnt == AT_FIRST)  samp_a <= line;
            if (cnt == AT_SECOND) samp_b <= line;
        end
    end

    assign bit_done = step && (cnt == AT_THIRD);
    assign bit_val  = vote3(samp_a, samp_b, line);

endmodule

// File: rtl/uart_os_rx_shift.sv
module uart_os_rx_shift #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);

    // LSB-first line order: new bits enter at the top and move down.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {bit_in, word[WIDTH-1:1]};
    end

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_x16,
    input  logic                 rx_en,
    input  logic                 nine_bit_mode,
    input  logic                 rx_line,
    output logic                 word_valid,
    output logic [DATA_BITS:0]   word_data,
    output logic                 frame_err
);

    localparam int              WW       = DATA_BITS + 1;
    localparam int              IW       = $clog2(WW);
    localparam logic [IW-1:0]   LAST_STD = IW'(DATA_BITS - 1);
    localparam logic [IW-1:0]   LAST_EXT = IW'(DATA_BITS);

    rx_state_t        state;
    rx_state_t        state_nxt;
    logic             line_s;
    logic             line_prev;
    logic             start_edge;
    logic             bit_done;
    logic             bit_val;
    logic [IW-1:0]    bit_idx;
    logic [IW-1:0]    bit_last;
    logic             nine_q;
    logic [WW-1:0]    shreg;
    logic             phase_restart;
    logic             phase_run;
    logic             shift_en;

    uart_os_rx_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (line_s)
    );

    assign start_edge    = tick_x16 && !line_s && line_prev;
    assign phase_restart = rx_en && (state == RX_IDLE) && start_edge;
    assign phase_run     = rx_en && (state != RX_IDLE);

    uart_os_rx_phase #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_x16),
        .restart  (phase_restart),
        .run      (phase_run),
        .line     (line_s),
        .bit_done (bit_done),
        .bit_val  (bit_val)
    );

    assign shift_en = rx_en && (state == RX_DATA) && bit_done;

    uart_os_rx_shift #(
        .WIDTH (WW)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (bit_val),
        .word     (shreg)
    );

    assign bit_last = nine_q ? LAST_EXT : LAST_STD;

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE:  if (start_edge) state_nxt = RX_START;
            RX_START: if (bit_done)   state_nxt = bit_val ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_done && (bit_idx == bit_last)) state_nxt = RX_STOP;
            RX_STOP:  if (bit_done)   state_nxt = RX_IDLE;
            default:                  state_nxt = RX_IDLE;
        endcase
    end

    // State register; a low enable forces idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= RX_IDLE;
        else if (!rx_en) state <= RX_IDLE;
        else             state <= state_nxt;
    end

    // Frame bookkeeping: edge history, bit index, width captured at start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_prev <= 1'b0;
            bit_idx   <= '0;
            nine_q    <= 1'b0;
        end else if (!rx_en) begin
            line_prev <= 1'b0;
            bit_idx   <= '0;
        end else begin
            if (tick_x16) line_prev <= line_s;
            if (phase_restart) nine_q <= nine_bit_mode;
            if (state == RX_START)                 bit_idx <= '0;
            else if ((state == RX_DATA) && bit_done) bit_idx <= bit_idx + IW'(1);
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
            frame_err  <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (rx_en && (state == RX_STOP) && bit_done) begin
                word_valid <= 1'b1;
                word_data  <= nine_q ? shreg : {1'b0, shreg[WW-1:1]};
                frame_err  <= !bit_val;
            end
        end
    end

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_en,
    input logic               tick_x16,
    input logic               word_valid,
    input logic [DATA_BITS:0] word_data,
    input logic               frame_err,
    input rx_state_t          state,
    input logic               nine_q
);

    assert_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && $past(state) == RX_IDLE) |-> $past(tick_x16));

    assert_std_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !nine_q) |-> (word_data[DATA_BITS] == 1'b0));

    assert_word_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ($past(state) == RX_STOP));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> ($stable(word_data) && $stable(frame_err)));

    assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == RX_IDLE));

    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !word_valid);

    assert_no_tick_no_move_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !tick_x16) |=> $stable(state));

endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .tick_x16   (tick_x16),
    .word_valid (word_valid),
    .word_data  (word_data),
    .frame_err  (frame_err),
    .state      (state),
    .nine_q     (nine_q)
);

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       nine = 1'b0;
    logic       line = 1'b1;
    logic       wv;
    logic [8:0] wd;
    logic       fe;

    always #5 clk = ~clk;

    uart_os_rx u_uart_os_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_x16      (tick),
        .rx_en         (rx_en),
        .nine_bit_mode (nine),
        .rx_line       (line),
        .word_valid    (wv),
        .word_data     (wd),
        .frame_err     (fe)
    );

    int         checks = 0;
    int         fails = 0;
    int         strobes = 0;
    int         run_len = 0;
    int         max_run = 0;
    logic [8:0] last_d = '0;
    logic       last_fe = 1'b0;

    always @(negedge clk) begin
        if (wv) begin
            strobes++;
            last_d  = wd;
            last_fe = fe;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One strobe period: line changes three clocks before the strobe.
    task automatic tick_step(input logic v);
        @(negedge clk) line = v;
        @(negedge clk);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic pause_line();
        for (int k = 0; k < 40; k++) begin
            @(negedge clk) line = ~line;
        end
    endtask

    // Frame bit b: 0 = start, 1..nb = data, nb+1 = stop. In-bit index t
    // equals the engine's strobe number minus one.
    task automatic send_frame(input logic nn, input logic [8:0] d, input logic st,
                              input int gbit, input bit two, input int drop_at,
                              input int pause_at, input int idle_steps);
        int nb;
        int step;
        nb   = nn ? 9 : 8;
        step = 0;
        @(negedge clk) nine = nn;
        for (int b = 0; b < nb + 2; b++) begin
            logic val;
            val = (b == 0) ? 1'b0 : ((b <= nb) ? d[b-1] : st);
            for (int t = 0; t < 16; t++) begin
                logic v;
                v = val;
                if (b == gbit && (t == 7 || (two && t == 6))) v = ~val;
                if (step == drop_at) begin
                    @(negedge clk) rx_en = 1'b0;
                end
                if (step == pause_at) pause_line();
                tick_step(v);
                step++;
            end
        end
        @(negedge clk) rx_en = 1'b1;
        for (int k = 0; k < idle_steps; k++) tick_step(1'b1);
    endtask

    // nine, data, stop, glitch bit (15 = none), two samples flipped
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 9'h0A5, 1'b1, 4'd15, 1'b0},
        {1'b0, 9'h000, 1'b1, 4'd15, 1'b0},
        {1'b0, 9'h0FF, 1'b1, 4'd15, 1'b0},
        {1'b0, 9'h03C, 1'b0, 4'd15, 1'b0},
        {1'b1, 9'h1A5, 1'b1, 4'd15, 1'b0},
        {1'b1, 9'h0FF, 1'b1, 4'd15, 1'b0},
        {1'b0, 9'h055, 1'b1, 4'd3,  1'b0},
        {1'b0, 9'h055, 1'b1, 4'd3,  1'b1},
        {1'b0, 9'h081, 1'b1, 4'd9,  1'b1},
        {1'b1, 9'h100, 1'b1, 4'd0,  1'b0},
        {1'b1, 9'h000, 1'b1, 4'd10, 1'b0},
        {1'b0, 9'h001, 1'b1, 4'd1,  1'b1}
    };

    task automatic run_vec(input logic [15:0] v);
        logic       nn;
        logic [8:0] d;
        logic       st;
        int         gb;
        bit         two;
        int         nb;
        int         base;
        logic [8:0] exp_d;
        logic       exp_fe;
        string      req;
        nn  = v[15];
        d   = v[14:6];
        st  = v[5];
        gb  = int'(v[4:1]);
        two = v[0];
        nb  = nn ? 9 : 8;
        exp_d = nn ? d : {1'b0, d[7:0]};
        if (two && gb >= 1 && gb <= nb) exp_d[gb-1] = ~exp_d[gb-1];
        exp_fe = !st || (two && gb == nb + 1);
        req = (gb != 15) ? "R4" : (nn ? "R6" : (!st ? "R7" : "R5"));
        base = strobes;
        send_frame(nn, d, st, gb, two, -1, -1, 6);
        chk(strobes == base + 1, "R8 word count", strobes - base, 1);
        chk(last_d == exp_d, req, int'(last_d), int'(exp_d));
        chk(last_fe == exp_fe, "R7 frame_err", int'(last_fe), int'(exp_fe));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int base;
        logic [8:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(wv == 1'b0, "R1 word_valid", int'(wv), 0);
        chk(wd == 9'h0, "R1 word_data", int'(wd), 0);
        chk(fe == 1'b0, "R1 frame_err", int'(fe), 0);

        rx_en = 1'b1;
        for (int k = 0; k < 4; k++) tick_step(1'b1);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R3: start bit low for only four strobes is rejected
        base = strobes;
        for (int k = 0; k < 4; k++) tick_step(1'b0);
        for (int k = 0; k < 200; k++) tick_step(1'b1);
        chk(strobes == base, "R3 false start", strobes - base, 0);
        run_vec({1'b0, 9'h0C3, 1'b1, 4'd15, 1'b0});

        // R2: line held low from enable produces nothing
        @(negedge clk) rx_en = 1'b0;
        for (int k = 0; k < 4; k++) tick_step(1'b0);
        @(negedge clk) rx_en = 1'b1;
        base = strobes;
        for (int k = 0; k < 200; k++) tick_step(1'b0);
        chk(strobes == base, "R2 no edge", strobes - base, 0);
        for (int k = 0; k < 4; k++) tick_step(1'b1);
        run_vec({1'b0, 9'h05A, 1'b1, 4'd15, 1'b0});

        // R9: disable mid-frame discards, whole-frame disable is ignored
        base = strobes;
        send_frame(1'b0, 9'h0E7, 1'b1, 15, 1'b0, 60, -1, 6);
        chk(strobes == base, "R9 mid-frame drop", strobes - base, 0);
        send_frame(1'b0, 9'h018, 1'b0, 15, 1'b0, 0, -1, 6);
        chk(strobes == base, "R9 disabled frame", strobes - base, 0);
        run_vec({1'b0, 9'h0B4, 1'b1, 4'd15, 1'b0});

        // R10: back-to-back frames
        base = strobes;
        send_frame(1'b0, 9'h096, 1'b1, 15, 1'b0, -1, -1, 0);
        chk(last_d == 9'h096, "R10 first word", int'(last_d), 'h96);
        send_frame(1'b1, 9'h169, 1'b1, 15, 1'b0, -1, -1, 6);
        chk(strobes == base + 2, "R10 word count", strobes - base, 2);
        chk(last_d == 9'h169, "R10 second word", int'(last_d), 'h169);

        // R11: strobe gap with line toggling mid-frame changes nothing
        base = strobes;
        send_frame(1'b0, 9'h03E, 1'b1, 15, 1'b0, -1, 80, 6);
        chk(strobes == base + 1, "R11 word count", strobes - base, 1);
        chk(last_d == 9'h03E, "R11 word", int'(last_d), 'h3E);

        // R8: outputs hold between strobes, strobe lasts one clock
        held = wd;
        for (int k = 0; k < 40; k++) tick_step(1'b1);
        chk(wd == held, "R8 hold", int'(wd), int'(held));
        chk(max_run == 1, "R8 strobe width", max_run, 1);

        summary();
        $finish;
    end

endmodule